// File: doc/BRIEF.md
# Composite Video Raster Timing Generator

This block derives the complete raster timing of a monochrome composite video frame from a single 8 MHz pixel clock. It keeps two counters: a horizontal pixel position and a vertical line position. From these it produces an active-low horizontal sync, an active-low vertical sync, a blanking flag and an active-video window flag. A downstream pixel fetch unit uses the positions to address its memory, and uses the active flag to decide when to load its shift register.

The raster is 512 pixel clocks per line and 312 lines per frame, so one frame takes 159744 clocks. Horizontal sync occupies the first 36 clocks of every line. Vertical sync occupies the first 4 lines of the frame. The visible window spans pixels 128 through 447 on lines 32 and later. The line counter steps on the same clock edge on which the pixel counter wraps, so there is no carry ripple between them. Every flag comes from a flip-flop that is decoded from the next position. As a result, the flags always describe the position shown on the counter outputs in the same cycle.

Top module: `composite_raster_timing`

## Requirements
- R1: While rst_n is sampled low on a rising clock edge, that edge sets pix_x=0, line_y=0, hsync_n=0, vsync_n=0, blank=1 and active=0. The frame restarts from position (0,0) after release, even if reset is applied mid-frame.
- R2: pix_x advances by one on every rising edge and wraps from 511 to 0. The k-th edge after reset release shows pix_x = k mod 512.
- R3: line_y advances by one on exactly the edge where pix_x wraps from 511 to 0, and wraps from 311 to 0. A frame is therefore 159744 clocks long.
- R4: hsync_n is 0 in exactly the cycles where pix_x < 36, and 1 otherwise.
- R5: vsync_n is 0 in exactly the cycles where line_y < 4, and 1 otherwise.
- R6: active is 1 in exactly the cycles where 128 <= pix_x < 448 and line_y >= 32.
- R7: blank is the inverse of active in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock (8 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_x | output | 9 | Current pixel position in the line |
| line_y | output | 9 | Current line position in the frame |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blank | output | 1 | High outside the active window |
| active | output | 1 | High inside the visible window |

## Verification
Every output is registered and carries zero added latency relative to the position counters. After the k-th rising edge following reset release, the outputs describe position k, with pix_x = k mod 512 and line_y = (k div 512) mod 312. The bench counts rising edges itself and samples on the falling edge after each one. It compares every cycle of a full frame, plus the wrap into the next frame, against that model. Reset takes effect on the first edge that samples rst_n low, so the reset checks sample on the falling edge right after that edge.

// File: rtl/vt_pkg.sv
// Package: shared types for the raster timing generator.
// Assumes: monochrome raster, one clock domain.
package vt_pkg;

    // Registered timing flags produced by the decoder.
    typedef struct packed {
        logic hsync_n;
        logic vsync_n;
        logic active;
        logic blank;
    } vt_flags_t;

endpackage

// File: rtl/raster_counter.sv
// Module: raster_counter
// Keeps the pixel and line positions of the raster. The line position
// advances on the same edge on which the pixel position wraps (no cascade).
// Also exposes the next position so that a decoder can register flags
// one cycle ahead. Assumes H_TOTAL, V_TOTAL >= 2; synchronous active-low reset.
module raster_counter #(
    parameter int H_TOTAL = 512,
    parameter int V_TOTAL = 312,
    localparam int XW = $clog2(H_TOTAL),
    localparam int YW = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [XW-1:0] cur_x,
    output logic [YW-1:0] cur_y,
    output logic [XW-1:0] nxt_x,
    output logic [YW-1:0] nxt_y
);

    logic x_last;
    logic y_last;

    // Compute the position that the next edge will load.
    always_comb begin
        x_last = (cur_x == XW'(H_TOTAL - 1));
        y_last = (cur_y == YW'(V_TOTAL - 1));
        nxt_x  = x_last ? '0 : cur_x + XW'(1);
        if (x_last) begin
            nxt_y = y_last ? '0 : cur_y + YW'(1);
        end else begin
            nxt_y = cur_y;
        end
    end

    // Hold the current position; reset returns to the frame origin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_x <= '0;
            cur_y <= '0;
        end else begin
            cur_x <= nxt_x;
            cur_y <= nxt_y;
        end
    end

endmodule

// File: rtl/sync_decode.sv
// Module: sync_decode
// Decodes sync, blank and active flags from the NEXT raster position and
// registers them, so the flags line up with the counter outputs and carry
// no decode glitches. The reset value is the decode of the origin (0,0).
// Assumes the window bounds lie inside the raster.
module sync_decode
    import vt_pkg::*;
#(
    parameter int H_TOTAL     = 512,
    parameter int V_TOTAL     = 312,
    parameter int HSYNC_LEN   = 36,
    parameter int VSYNC_LINES = 4,
    parameter int ACT_X_FIRST = 128,
    parameter int ACT_X_STOP  = 448,
    parameter int ACT_Y_FIRST = 32,
    localparam int XW = $clog2(H_TOTAL),
    localparam int YW = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [XW-1:0] nxt_x,
    input  logic [YW-1:0] nxt_y,
    output vt_flags_t     flags
);

    // Pure decode of one raster position into timing flags.
    function automatic vt_flags_t decode(input logic [XW-1:0] x, input logic [YW-1:0] y);
        vt_flags_t f;
        f.hsync_n = !(x < XW'(HSYNC_LEN));
        f.vsync_n = !(y < YW'(VSYNC_LINES));
        f.active  = (x >= XW'(ACT_X_FIRST)) && (x < XW'(ACT_X_STOP))
                    && (y >= YW'(ACT_Y_FIRST));
        f.blank   = !f.active;
        return f;
    endfunction

    localparam vt_flags_t ORIGIN_FLAGS = decode('0, '0);

    vt_flags_t flags_d;

    // Decode the position the counters will hold after this edge.
    always_comb begin
        flags_d = decode(nxt_x, nxt_y);
    end

    // Register the flags; reset loads the origin decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= ORIGIN_FLAGS;
        end else begin
            flags <= flags_d;
        end
    end

endmodule

// File: rtl/composite_raster_timing.sv
// Module: composite_raster_timing (top)
// Raster timing for a monochrome composite frame: position counters plus
// registered active-low syncs, blanking and active-window flags, all valid
// in the same cycle. Single clock, synchronous active-low reset.
module composite_raster_timing
    import vt_pkg::*;
#(
    parameter int H_TOTAL     = 512,
    parameter int V_TOTAL     = 312,
    parameter int HSYNC_LEN   = 36,
    parameter int VSYNC_LINES = 4,
    parameter int ACT_X_FIRST = 128,
    parameter int ACT_X_STOP  = 448,
    parameter int ACT_Y_FIRST = 32,
    localparam int XW = $clog2(H_TOTAL),
    localparam int YW = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [XW-1:0] pix_x,
    output logic [YW-1:0] line_y,
    output logic          hsync_n,
    output logic          vsync_n,
    output logic          blank,
    output logic          active
);

    logic [XW-1:0] nx;
    logic [YW-1:0] ny;
    vt_flags_t     fl;

    raster_counter #(
        .H_TOTAL(H_TOTAL),
        .V_TOTAL(V_TOTAL)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .cur_x (pix_x),
        .cur_y (line_y),
        .nxt_x (nx),
        .nxt_y (ny)
    );

    sync_decode #(
        .H_TOTAL    (H_TOTAL),
        .V_TOTAL    (V_TOTAL),
        .HSYNC_LEN  (HSYNC_LEN),
        .VSYNC_LINES(VSYNC_LINES),
        .ACT_X_FIRST(ACT_X_FIRST),
        .ACT_X_STOP (ACT_X_STOP),
        .ACT_Y_FIRST(ACT_Y_FIRST)
    ) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt_x (nx),
        .nxt_y (ny),
        .flags (fl)
    );

    // Drive the flag ports from the registered decode.
    always_comb begin
        hsync_n = fl.hsync_n;
        vsync_n = fl.vsync_n;
        blank   = fl.blank;
        active  = fl.active;
    end

endmodule

// File: rtl/raster_timing_checker.sv
// Module: raster_timing_checker
// Property checks on the top-level ports of composite_raster_timing.
// Attached with bind; observes only and drives nothing.
module raster_timing_checker #(
    parameter int H_TOTAL     = 512,
    parameter int V_TOTAL     = 312,
    parameter int HSYNC_LEN   = 36,
    parameter int VSYNC_LINES = 4,
    parameter int ACT_X_FIRST = 128,
    parameter int ACT_X_STOP  = 448,
    parameter int ACT_Y_FIRST = 32,
    localparam int XW = $clog2(H_TOTAL),
    localparam int YW = $clog2(V_TOTAL)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [XW-1:0] pix_x,
    input logic [YW-1:0] line_y,
    input logic          hsync_n,
    input logic          vsync_n,
    input logic          blank,
    input logic          active
);

    localparam logic [XW-1:0] XL = XW'(H_TOTAL - 1);
    localparam logic [YW-1:0] YL = YW'(V_TOTAL - 1);

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (pix_x == '0 && line_y == '0 && !hsync_n && !vsync_n && blank && !active));

    a_r2_pix_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_x != XL) |=> (pix_x == XW'($past(pix_x) + XW'(1))) && $stable(line_y));

    a_r2_pix_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_x == XL) |=> (pix_x == '0));

    a_r3_line_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_x == XL && line_y != YL) |=> (line_y == YW'($past(line_y) + YW'(1))));

    a_r3_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_x == XL && line_y == YL) |=> (line_y == '0 && pix_x == '0));

    a_r4_hsync_window: assert property (@(posedge clk) disable iff (!rst_n)
        hsync_n == (pix_x >= XW'(HSYNC_LEN)));

    a_r5_vsync_window: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_n == (line_y >= YW'(VSYNC_LINES)));

    a_r6_active_window: assert property (@(posedge clk) disable iff (!rst_n)
        active == (pix_x >= XW'(ACT_X_FIRST) && pix_x < XW'(ACT_X_STOP)
                   && line_y >= YW'(ACT_Y_FIRST)));

    a_r7_blank_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        blank != active);

endmodule

bind composite_raster_timing raster_timing_checker #(
    .H_TOTAL    (H_TOTAL),
    .V_TOTAL    (V_TOTAL),
    .HSYNC_LEN  (HSYNC_LEN),
    .VSYNC_LINES(VSYNC_LINES),
    .ACT_X_FIRST(ACT_X_FIRST),
    .ACT_X_STOP (ACT_X_STOP),
    .ACT_Y_FIRST(ACT_Y_FIRST)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .pix_x  (pix_x),
    .line_y (line_y),
    .hsync_n(hsync_n),
    .vsync_n(vsync_n),
    .blank  (blank),
    .active (active)
);

// File: tb/composite_raster_timing_tb.sv
// Bench for composite_raster_timing: vector table walk with a per-cycle
// sweep against an independent model, then directed reset cases.
module composite_raster_timing_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] pix_x;
    logic [8:0] line_y;
    logic       hsync_n, vsync_n, blank, active;

    int errors = 0;
    int checks = 0;
    int cyc    = 0;
    int sw_r2 = 0, sw_r3 = 0, sw_r4 = 0, sw_r5 = 0, sw_r6 = 0, sw_r7 = 0;

    always #5 clk = ~clk;

    composite_raster_timing u_dut (
        .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .line_y(line_y),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .blank(blank), .active(active)
    );

    // Vectors: cycle after release, x, y, hsync_n, vsync_n, active.
    localparam int NV = 14;
    localparam int VC[NV] = '{0, 35, 36, 511, 512, 2047, 2048, 16072, 16511, 16512, 16831, 16832, 159743, 159744};
    localparam int VX[NV] = '{0, 35, 36, 511, 0, 511, 0, 200, 127, 128, 447, 448, 511, 0};
    localparam int VY[NV] = '{0, 0, 0, 0, 1, 3, 4, 31, 32, 32, 32, 32, 311, 0};
    localparam int VH[NV] = '{0, 0, 1, 1, 0, 1, 0, 1, 1, 1, 1, 1, 1, 0};
    localparam int VV[NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 1, 1, 0};
    localparam int VA[NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0};

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Advance one clock and compare all outputs against the model.
    task automatic step_and_sweep();
        int ex, ey;
        @(posedge clk);
        @(negedge clk);
        cyc++;
        ex = cyc % 512;
        ey = (cyc / 512) % 312;
        if (int'(pix_x) != ex) sw_r2++;
        if (int'(line_y) != ey) sw_r3++;
        if (hsync_n != (ex >= 36)) sw_r4++;
        if (vsync_n != (ey >= 4)) sw_r5++;
        if (active != (ex >= 128 && ex < 448 && ey >= 32)) sw_r6++;
        if (blank == active) sw_r7++;
    endtask

    task automatic chk_reset_state(input string tag);
        chk(pix_x == 0,  "R1", {tag, " pix_x"},   int'(pix_x), 0);
        chk(line_y == 0, "R1", {tag, " line_y"},  int'(line_y), 0);
        chk(!hsync_n,    "R1", {tag, " hsync_n"}, int'(hsync_n), 0);
        chk(!vsync_n,    "R1", {tag, " vsync_n"}, int'(vsync_n), 0);
        chk(blank,       "R1", {tag, " blank"},   int'(blank), 1);
        chk(!active,     "R1", {tag, " active"},  int'(active), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (195000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_reset_state("power-up");          // R1
        rst_n = 1'b1;
        cyc = 0;

        for (int i = 0; i < NV; i++) begin
            while (cyc < VC[i]) step_and_sweep();
            chk(int'(pix_x) == VX[i] && int'(line_y) == VY[i], "R2/R3 position",
                $sformatf("cycle %0d x*1000+y", VC[i]), int'(pix_x) * 1000 + int'(line_y), VX[i] * 1000 + VY[i]);
            chk(int'(hsync_n) == VH[i], "R4", $sformatf("cycle %0d hsync_n", VC[i]), int'(hsync_n), VH[i]);
            chk(int'(vsync_n) == VV[i], "R5", $sformatf("cycle %0d vsync_n", VC[i]), int'(vsync_n), VV[i]);
            chk(int'(active) == VA[i],  "R6", $sformatf("cycle %0d active", VC[i]), int'(active), VA[i]);
            chk(int'(blank) == 1 - VA[i], "R7", $sformatf("cycle %0d blank", VC[i]), int'(blank), 1 - VA[i]);
        end

        // Full-frame sweep results, one check per requirement.
        chk(sw_r2 == 0, "R2", "sweep pix_x mismatches", sw_r2, 0);
        chk(sw_r3 == 0, "R3", "sweep line_y mismatches", sw_r3, 0);
        chk(sw_r4 == 0, "R4", "sweep hsync_n mismatches", sw_r4, 0);
        chk(sw_r5 == 0, "R5", "sweep vsync_n mismatches", sw_r5, 0);
        chk(sw_r6 == 0, "R6", "sweep active mismatches", sw_r6, 0);
        chk(sw_r7 == 0, "R7", "sweep blank mismatches", sw_r7, 0);

        // Mid-frame reset inside the active window: R1 restart.
        while (cyc < 159744 + 40 * 512 + 200) step_and_sweep();
        chk(active == 1'b1, "R6", "pre-reset active", int'(active), 1);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk_reset_state("mid-frame");         // R1
        @(posedge clk);
        @(negedge clk);
        chk_reset_state("held");              // R1
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(pix_x == 1 && line_y == 0, "R1", "restart position x*1000+y",
            int'(pix_x) * 1000 + int'(line_y), 1000);
        chk(!hsync_n && !vsync_n, "R4", "restart syncs low",
            int'(hsync_n) * 10 + int'(vsync_n), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule